// File: doc/BRIEF.md
# Split Direct-Mapped Address Translation Cache

This block caches recent virtual-to-physical page translations in two independent direct-mapped arrays. One array serves process space and the other serves system space, and the top bit of the virtual address picks between them. A requester presents a 32-bit virtual address with a lookup strobe and a request vector that carries one read bit and one write bit per privilege mode. The block answers in the same cycle with a hit flag and a physical address. That address is the cached frame number joined to the 9-bit page offset.

On a miss, an external page-table walker writes a converted entry back through the refill port. The entry carries a tag, the granted access bits, a modified flag and a frame number. A control port can empty the process array alone or both arrays, or knock out the one entry that a given address maps to. A separate probe port reports whether the indexed tag matches a given address's page number, and it does not look at access rights.

Top module: `stb_split_tlb`

## Requirements
- R1: Virtual address bit 31 selects the system array when 1 and the process array when 0, for lookup, probe and single-entry invalidate; the refill port selects the array by bit 22 of its page number (the same bit).
- R2: A strobed lookup hits when the stored tag equals VA[31:9] and the stored access bits AND the request bits is nonzero; on a hit the physical address is {frame, VA[8:0]}. Request bits: [3:0] read for modes 0..3 (kernel, executive, supervisor, user), [7:4] write for the same modes.
- R3: A lookup whose request has any of bits [7:4] set also needs the stored modified flag; a clean entry misses even with matching tag and access bits.
- R4: An invalidated entry holds all ones in its 24-bit tag and in its data, so it never hits and never probes true, even for VA 0xFFFFFFFF with all request bits set.
- R5: Invalidate-all with flag 0 empties only the process array; with flag 1 it empties both arrays.
- R6: Single-entry invalidate empties only the entry at index VA[14:9] in the array chosen by VA bit 31; other entries keep hitting.
- R7: The probe output is 1 when the indexed tag of the selected array equals VA[31:9], whatever the access bits and modified flag are.
- R8: Each array has 64 entries indexed by page-number bits [5:0], and the tag holds the full 23-bit page number, so two pages that share an index replace each other and a lookup with the other page misses.
- R9: Reset invalidates every entry of both arrays.
- R10: Lookup and probe are combinational. Refill and invalidate take effect at the next rising clock edge, and an invalidate to the same entry in the same cycle beats the refill.
- R11: With the lookup strobe low, the hit output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | 32 | Lookup virtual address |
| lk_req | input | 8 | Requested access: [3:0] read per mode, [7:4] write per mode |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | PA_W | Translated physical address |
| probe_va | input | 32 | Address to probe |
| probe_hit | output | 1 | Indexed tag matches probe page number |
| inv_all_req | input | 1 | Invalidate-all command |
| inv_all_sys | input | 1 | Invalidate-all flag: 1 also clears system array |
| inv_one_req | input | 1 | Single-entry invalidate command |
| inv_one_va | input | 32 | Address whose entry is invalidated |
| fill_req | input | 1 | Refill write strobe |
| fill_vpn | input | 23 | Refill tag (page number) |
| fill_acc | input | 8 | Refill access bits, same encoding as lk_req |
| fill_mod | input | 1 | Refill modified flag |
| fill_pfn | input | PA_W-9 | Refill frame number |

## Verification
The hit, physical address and probe outputs depend only on the current inputs and the stored state. So the bench drives a lookup after a falling edge and samples 2 time units later, well before the next rising edge. A refill or invalidate is driven for one full clock period and lands on the rising edge inside it. Every check that depends on it is made after that edge, and one check samples inside the refill cycle to confirm the entry is not yet visible. Reset is checked through lookups and probes only after the reset is released.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 9;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int TAG_W  = VPN_W + 1;
  localparam int ACC_W  = 8;
  localparam int MODE_N = ACC_W / 2;

  function automatic logic [VPN_W-1:0] va_vpn(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] va_off(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic va_space(input logic [VA_W-1:0] va);
    return va[VA_W-1];
  endfunction

  function automatic logic req_is_write(input logic [ACC_W-1:0] req);
    return |req[ACC_W-1:MODE_N];
  endfunction

  function automatic logic acc_grant(input logic [ACC_W-1:0] ent,
                                     input logic [ACC_W-1:0] req);
    return |(ent & req);
  endfunction

  function automatic logic [TAG_W-1:0] make_tag(input logic [VPN_W-1:0] vpn);
    return {1'b0, vpn};
  endfunction
endpackage

// File: rtl/stb_bank.sv
module stb_bank #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 24,
  parameter int DATA_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              clr_one,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  pr_idx,
  output logic [TAG_W-1:0]  pr_tag
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [DATA_W-1:0] data_q [ENTRIES];
  logic [ENTRIES-1:0] kill_vec;
  logic [ENTRIES-1:0] load_vec;

  // per-entry decode; invalidate outranks refill
  for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
    assign kill_vec[g] = clr_all | (clr_one && (clr_idx == IDX_W'(g)));
    assign load_vec[g] = wr_en && (wr_idx == IDX_W'(g)) && !kill_vec[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '1;
        data_q[i] <= '1;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (kill_vec[i]) begin
          tag_q[i]  <= '1;
          data_q[i] <= '1;
        end else if (load_vec[i]) begin
          tag_q[i]  <= wr_tag;
          data_q[i] <= wr_data;
        end
      end
    end
  end

  assign rd_tag  = tag_q[rd_idx];
  assign rd_data = data_q[rd_idx];
  assign pr_tag  = tag_q[pr_idx];

  assert_single_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_one |=> (&tag_q[$past(clr_idx)]) && (&data_q[$past(clr_idx)]));

  assert_full_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (&tag_q[0]) && (&tag_q[ENTRIES-1]));

  assert_refill_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !kill_vec[wr_idx]) |=>
      (tag_q[$past(wr_idx)] == $past(wr_tag)) && (data_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/stb_hit_eval.sv
module stb_hit_eval
  import stb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [VPN_W-1:0] vpn,
  input  logic [ACC_W-1:0] req,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [ACC_W-1:0] ent_acc,
  input  logic             ent_mod,
  output logic             hit,
  output logic             tag_eq,
  output logic             grant_ok,
  output logic             dirty_ok
);
  assign tag_eq   = (ent_tag == make_tag(vpn));
  assign grant_ok = acc_grant(ent_acc, req);
  assign dirty_ok = !req_is_write(req) || ent_mod;
  assign hit      = valid && tag_eq && grant_ok && dirty_ok;

  assert_write_needs_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && req_is_write(req)) |-> ent_mod);

  assert_no_strobe_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !hit);
endmodule

// File: rtl/stb_split_tlb.sv
module stb_split_tlb
  import stb_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int PA_W  = 30
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [31:0]           lk_va,
  input  logic [7:0]            lk_req,
  output logic                  lk_hit,
  output logic [PA_W-1:0]       lk_pa,
  input  logic [31:0]           probe_va,
  output logic                  probe_hit,
  input  logic                  inv_all_req,
  input  logic                  inv_all_sys,
  input  logic                  inv_one_req,
  input  logic [31:0]           inv_one_va,
  input  logic                  fill_req,
  input  logic [22:0]           fill_vpn,
  input  logic [7:0]            fill_acc,
  input  logic                  fill_mod,
  input  logic [PA_W-10:0]      fill_pfn
);
  localparam int PFN_W  = PA_W - OFF_W;
  localparam int DATA_W = PFN_W + 1 + ACC_W;
  localparam int BANKS  = 2;

  logic [TAG_W-1:0]  rd_tag  [BANKS];
  logic [DATA_W-1:0] rd_data [BANKS];
  logic [TAG_W-1:0]  pr_tag  [BANKS];

  logic [VPN_W-1:0] lk_vpn, pr_vpn, inv_vpn;
  assign lk_vpn  = va_vpn(lk_va);
  assign pr_vpn  = va_vpn(probe_va);
  assign inv_vpn = va_vpn(inv_one_va);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic clr_all_b, clr_one_b, wr_b;
    assign clr_all_b = inv_all_req && ((b == 0) || inv_all_sys);
    assign clr_one_b = inv_one_req && (va_space(inv_one_va) == 1'(b));
    assign wr_b      = fill_req && (fill_vpn[VPN_W-1] == 1'(b));

    stb_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (clr_all_b),
      .clr_one (clr_one_b),
      .clr_idx (inv_vpn[IDX_W-1:0]),
      .wr_en   (wr_b),
      .wr_idx  (fill_vpn[IDX_W-1:0]),
      .wr_tag  (make_tag(fill_vpn)),
      .wr_data ({fill_pfn, fill_mod, fill_acc}),
      .rd_idx  (lk_vpn[IDX_W-1:0]),
      .rd_tag  (rd_tag[b]),
      .rd_data (rd_data[b]),
      .pr_idx  (pr_vpn[IDX_W-1:0]),
      .pr_tag  (pr_tag[b])
    );
  end

  // selected entry, visible for the checks below
  logic              sel_sys;
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_data;
  logic [PFN_W-1:0]  sel_pfn;
  logic              sel_mod;
  logic [ACC_W-1:0]  sel_acc;
  logic              ev_tag_eq, ev_grant, ev_dirty;

  assign sel_sys  = va_space(lk_va);
  assign sel_tag  = rd_tag[sel_sys];
  assign sel_data = rd_data[sel_sys];
  assign {sel_pfn, sel_mod, sel_acc} = sel_data;

  stb_hit_eval u_eval (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (lk_valid),
    .vpn      (lk_vpn),
    .req      (lk_req),
    .ent_tag  (sel_tag),
    .ent_acc  (sel_acc),
    .ent_mod  (sel_mod),
    .hit      (lk_hit),
    .tag_eq   (ev_tag_eq),
    .grant_ok (ev_grant),
    .dirty_ok (ev_dirty)
  );

  assign lk_pa     = {sel_pfn, va_off(lk_va)};
  assign probe_hit = (pr_tag[va_space(probe_va)] == make_tag(pr_vpn));

  assert_invalid_never_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !sel_tag[TAG_W-1]);

  assert_probe_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit |-> !pr_tag[va_space(probe_va)][TAG_W-1]);
endmodule

// File: tb/stb_split_tlb_tb.sv
module stb_split_tlb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 30;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0; logic [31:0] lk_va = 0; logic [7:0] lk_req = 0;
  logic lk_hit; logic [PA_W-1:0] lk_pa;
  logic [31:0] probe_va = 0; logic probe_hit;
  logic inv_all_req = 0, inv_all_sys = 0, inv_one_req = 0;
  logic [31:0] inv_one_va = 0;
  logic fill_req = 0; logic [22:0] fill_vpn = 0; logic [7:0] fill_acc = 0;
  logic fill_mod = 0; logic [PA_W-10:0] fill_pfn = 0;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stb_split_tlb #(.IDX_W(6), .PA_W(PA_W)) u_dut (.*);

  typedef struct packed {
    logic [22:0] f_vpn; logic [7:0] f_acc; logic f_mod; logic [20:0] f_pfn;
    logic [31:0] l_va;  logic [7:0] l_req; logic e_hit; logic [29:0] e_pa;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{23'h000005, 8'h0F, 1'b0, 21'h000123, 32'h0000_0A1A, 8'h01, 1'b1, 30'h0002_461A}, // R2 read
    '{23'h000006, 8'h11, 1'b0, 21'h000055, 32'h0000_0C00, 8'h10, 1'b0, 30'h0},          // R3 clean write
    '{23'h000007, 8'h11, 1'b1, 21'h1FFFFF, 32'h0000_0FFF, 8'h10, 1'b1, 30'h3FFF_FFFF}, // R3 dirty write
    '{23'h000008, 8'h01, 1'b1, 21'h000010, 32'h0000_1000, 8'h08, 1'b0, 30'h0},          // R2 access miss
    '{23'h400009, 8'hFF, 1'b1, 21'h000042, 32'h8000_1255, 8'h80, 1'b1, 30'h0000_8455}, // R1 system
    '{23'h000049, 8'hFF, 1'b1, 21'h000077, 32'h0000_1255, 8'h01, 1'b0, 30'h0}           // R8 alias
  };

  task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic fill(input logic [22:0] v, input logic [7:0] a, input logic m, input logic [20:0] p);
    @(negedge clk);
    fill_req = 1; fill_vpn = v; fill_acc = a; fill_mod = m; fill_pfn = p;
    @(negedge clk);
    fill_req = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] rq, input logic e_hit, input string tag);
    lk_valid = 1; lk_va = va; lk_req = rq;
    #2;
    chk(lk_hit == e_hit, tag, 64'(lk_hit), 64'(e_hit));
    lk_valid = 0;
  endtask

  task automatic probe(input logic [31:0] va, input logic e, input string tag);
    probe_va = va;
    #2;
    chk(probe_hit == e, tag, 64'(probe_hit), 64'(e));
  endtask

  task automatic inv_all(input logic sys);
    @(negedge clk); inv_all_req = 1; inv_all_sys = sys;
    @(negedge clk); inv_all_req = 0;
  endtask

  task automatic inv_one(input logic [31:0] va);
    @(negedge clk); inv_one_req = 1; inv_one_va = va;
    @(negedge clk); inv_one_req = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    look(32'h0000_0000, 8'hFF, 1'b0, "R9 reset lookup");
    probe(32'h0000_0000, 1'b0, "R9 reset probe");
    // R4 all-ones address never matches an invalid entry
    look(32'hFFFF_FFFF, 8'hFF, 1'b0, "R4 all-ones lookup");
    probe(32'hFFFF_FFFF, 1'b0, "R4 all-ones probe");

    foreach (VECS[i]) begin
      fill(VECS[i].f_vpn, VECS[i].f_acc, VECS[i].f_mod, VECS[i].f_pfn);
      look(VECS[i].l_va, VECS[i].l_req, VECS[i].e_hit, "R2 vector hit");
      if (VECS[i].e_hit)
        chk(lk_pa == VECS[i].e_pa, "R2 vector pa", 64'(lk_pa), 64'(VECS[i].e_pa));
    end

    // R1 system entry unaffected by process alias in same index
    look(32'h8000_1255, 8'h01, 1'b1, "R1 system still hits");
    look(32'h0000_9200, 8'h01, 1'b1, "R8 alias page hits");
    // R7 probe ignores access bits
    probe(32'h0000_1000, 1'b1, "R7 probe despite access");
    probe(32'h0000_0C00, 1'b1, "R7 probe clean entry");
    // R11 no strobe
    lk_va = 32'h0000_0A1A; lk_req = 8'h01; lk_valid = 0; #2;
    chk(lk_hit == 1'b0, "R11 no strobe", 64'(lk_hit), 64'd0);

    // R6 single invalidate of system index 9
    inv_one(32'h8000_1255);
    look(32'h8000_1255, 8'h01, 1'b0, "R6 cleared system entry");
    look(32'h0000_9200, 8'h01, 1'b1, "R6 process entry kept");
    look(32'h0000_0A1A, 8'h01, 1'b1, "R6 other index kept");

    // R5 invalidate-all flag 0 then 1
    fill(23'h400009, 8'hFF, 1'b1, 21'h42);
    inv_all(1'b0);
    look(32'h0000_0A1A, 8'h01, 1'b0, "R5 process cleared");
    look(32'h8000_1255, 8'h01, 1'b1, "R5 system kept");
    inv_all(1'b1);
    look(32'h8000_1255, 8'h01, 1'b0, "R5 system cleared");

    // R10 timing: not visible inside fill cycle, visible after edge
    @(negedge clk);
    fill_req = 1; fill_vpn = 23'h000003; fill_acc = 8'h01; fill_mod = 0; fill_pfn = 21'h5;
    look(32'h0000_0600, 8'h01, 1'b0, "R10 before edge");
    @(negedge clk); fill_req = 0;
    look(32'h0000_0600, 8'h01, 1'b1, "R10 after edge");
    chk(lk_pa == 30'h0000_0A00, "R10 pa", 64'(lk_pa), 64'h0A00);

    // R10 invalidate beats refill at same index
    @(negedge clk);
    fill_req = 1; fill_vpn = 23'h000004; fill_acc = 8'h01;
    inv_one_req = 1; inv_one_va = 32'h0000_0800;
    @(negedge clk); fill_req = 0; inv_one_req = 0;
    look(32'h0000_0800, 8'h01, 1'b0, "R10 invalidate wins");
    // R10 refill at different index survives a single invalidate
    @(negedge clk);
    fill_req = 1; fill_vpn = 23'h00000A; fill_acc = 8'h01;
    inv_one_req = 1; inv_one_va = 32'h0000_0600;
    @(negedge clk); fill_req = 0; inv_one_req = 0;
    look(32'h0000_1400, 8'h01, 1'b1, "R10 other index refill");
    look(32'h0000_0600, 8'h01, 1'b0, "R10 target cleared");

    // R9 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    look(32'h0000_1400, 8'h01, 1'b0, "R9 reset clears");
    probe(32'h0000_1400, 1'b0, "R9 reset probe clears");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule